// File: doc/BRIEF.md
# Input Event Word Queue

This block sits behind a small register window and collects input events (an event type, an event code and a value, each 32 bits wide) from an upstream event source. Each accepted event becomes three consecutive 32-bit words in a circular word store. Software takes them out one word at a time by reading a single pop register, so one event costs three reads. An interrupt line tells software that at least one whole event is waiting.

The same window also offers read-only description pages. Writing the pop register's offset selects a page. A length register gives the page's entry count, and a run of data words gives the entries. The pages are a device name, the supported-code bitmask for each event type, and the range table of the absolute axes. The page contents come from parameters. The interrupt is held off after reset, while events keep collecting, until software has read the length register with the absolute-range page selected. That read marks the driver as ready.

The register window has no wait states. Read data is combinational from the address and the registered state. Pops, page writes and event pushes all take effect at the rising clock edge where their strobe is high.

Top module: `evq_input_dev`

## Requirements
- R1: After reset the interrupt is low, the store is empty (a read of offset 0x00 returns 0) and the selected page is the name page (0x00000).
- R2: An accepted event is stored as the three words type, code, value. Successive reads of offset 0x00 return them in that order, with events in arrival order.
- R3: If fewer than three word slots are free at the edge where an event arrives, the whole event is discarded and the stored words stay untouched. The store never holds more than DEPTH_WORDS words.
- R4: A read of offset 0x00 while the store is empty returns 0 and moves no pointer, so the next event is later read back complete, starting with its type.
- R5: Until the arming step, the interrupt stays low whatever the store holds, and events are still stored. The arming step is a read of offset 0x04 while page 0x20003 is selected.
- R6: Once armed, the interrupt is high exactly when the store holds three or more words. It is low when it holds zero, one or two.
- R7: Arming is permanent until reset. A length read on any other page does not arm.
- R8: A write to offset 0x00 selects the page given by the write data. A read of offset 0x04 returns the entry count: NAME_CHARS for page 0x00000, MASK_BYTES for 0x10001, 0x10002 and 0x10003 (key, relative, absolute types), 4*ABS_AXES for 0x20003, and 0 for any other value.
- R9: A read at offset 0x08+4*i returns entry i of the selected page. On the name page that is character i of NAME_TEXT, first character first. On page 0x10000+t it is byte i of type t's code mask, where bit b of byte i stands for code 8*i+b. Entries at or past the count read as 0.
- R10: On page 0x20003, entry 4*k holds the minimum and entry 4*k+1 the maximum of axis k. Entries 4*k+2 and 4*k+3 (fuzz, flat) are 0.
- R11: Writes to offsets other than 0x00 change nothing. Reads of offsets 0x04 and above never change the store contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Event present this cycle |
| ev_type | input | 32 | Event type word |
| ev_code | input | 32 | Event code word |
| ev_value | input | 32 | Event value word |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the strobe cycle |
| irq | output | 1 | Interrupt request, level |

## Verification
The embedded properties watch, on every cycle, that the store never overflows, that a refused event or an empty pop leaves the store level and pointers alone, that an accepted event adds exactly three words, that the interrupt is silent before arming and whenever the store is empty, and that arming never clears. The word order, the page contents, the lazy arming sequence and the interrupt tracking complete events versus a partial leftover can only be shown by the bench's scenarios. In those scenarios a word-level model of the store predicts every pop value and interrupt level during a randomized mix of pushes and pops, alongside directed fill-to-overflow and empty-read cases.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef logic [31:0] word_t;

  // register offsets (byte addresses)
  localparam int unsigned OFS_POP  = 0;
  localparam int unsigned OFS_LEN  = 4;
  localparam int unsigned OFS_DATA = 8;

  // page selector encodings
  localparam word_t PG_NAME     = 32'h0000_0000;
  localparam word_t PG_MASK_BAS = 32'h0001_0000;
  localparam word_t PG_RANGE    = 32'h0002_0003;

  typedef enum logic [15:0] {
    EVT_SYN = 16'd0,
    EVT_KEY = 16'd1,
    EVT_REL = 16'd2,
    EVT_ABS = 16'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    PK_NAME,
    PK_KEY,
    PK_REL,
    PK_ABS,
    PK_RANGE,
    PK_NONE
  } page_kind_e;
endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/evq_word_ring.sv
module evq_word_ring
  import evq_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  word_t         w0_i,
  input  word_t         w1_i,
  input  word_t         w2_i,
  input  logic          pop_i,
  output word_t         head_o,
  output logic [CW-1:0] level_o
);
  localparam int SLACK = DEPTH - 3;

  word_t          mem [DEPTH];
  logic [PW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]  lvl_q, lvl_d;
  logic           room, push_ok, pop_ok;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  always_comb begin
    room    = int'(lvl_q) <= SLACK;
    push_ok = push_i && room;
    pop_ok  = pop_i && (lvl_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    lvl_d   = lvl_q;
    if (push_ok) wr_d = adv(wr_q, 3);
    if (pop_ok)  rd_d = adv(rd_q, 1);
    case ({push_ok, pop_ok})
      2'b10:   lvl_d = lvl_q + CW'(3);
      2'b01:   lvl_d = lvl_q - CW'(1);
      2'b11:   lvl_d = lvl_q + CW'(2);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_q]         <= w0_i;
      mem[adv(wr_q, 1)] <= w1_i;
      mem[adv(wr_q, 2)] <= w2_i;
    end
  end

  assign head_o  = (lvl_q != '0) ? mem[rd_q] : '0;
  assign level_o = lvl_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl_q) <= DEPTH); // R3
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && int'(lvl_q) > SLACK && !pop_i) |=> $stable(lvl_q)); // R3
  AST_EMPTY_POP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && lvl_q == '0 && !push_i) |=> ($stable(rd_q) && lvl_q == '0)); // R4
  AST_TRIPLE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && int'(lvl_q) <= SLACK && !pop_i) |=> (lvl_q == $past(lvl_q) + CW'(3))); // R2
endmodule

// File: rtl/evq_page_rom.sv
module evq_page_rom
  import evq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int NAME_CHARS = 6,
  parameter logic [8*NAME_CHARS-1:0] NAME_TEXT = "evqkbd",
  parameter int MASK_BYTES = 4,
  parameter logic [8*MASK_BYTES-1:0] KEY_MASK = 32'h0000_1F06,
  parameter logic [8*MASK_BYTES-1:0] REL_MASK = 32'h0000_0003,
  parameter logic [8*MASK_BYTES-1:0] ABS_MASK = 32'h0000_0007,
  parameter int ABS_AXES = 3,
  parameter logic [32*ABS_AXES-1:0] ABS_MIN = {32'd0, 32'd16, 32'd0},
  parameter logic [32*ABS_AXES-1:0] ABS_MAX = {32'd1, 32'd479, 32'd319}
) (
  input  word_t            page_i,
  input  logic [IDX_W-1:0] idx_i,
  output word_t            len_o,
  output word_t            data_o
);
  localparam int RANGE_WORDS = 4 * ABS_AXES;

  page_kind_e kind;
  int         idx;
  logic [8*MASK_BYTES-1:0] mask_sel;

  always_comb begin
    kind = PK_NONE;
    if (page_i == PG_NAME)  kind = PK_NAME;
    else if (page_i == PG_RANGE) kind = PK_RANGE;
    else if (page_i[31:16] == PG_MASK_BAS[31:16]) begin
      case (page_i[15:0])
        EVT_KEY: kind = PK_KEY;
        EVT_REL: kind = PK_REL;
        EVT_ABS: kind = PK_ABS;
        default: kind = PK_NONE;
      endcase
    end
  end

  always_comb begin
    case (kind)
      PK_KEY:  mask_sel = KEY_MASK;
      PK_REL:  mask_sel = REL_MASK;
      PK_ABS:  mask_sel = ABS_MASK;
      default: mask_sel = '0;
    endcase
  end

  always_comb begin
    idx    = int'(idx_i);
    len_o  = '0;
    data_o = '0;
    case (kind)
      PK_NAME: begin
        len_o = 32'(NAME_CHARS);
        if (idx < NAME_CHARS)
          data_o = {24'd0, NAME_TEXT[8*(NAME_CHARS-1-idx) +: 8]};
      end
      PK_KEY, PK_REL, PK_ABS: begin
        len_o = 32'(MASK_BYTES);
        if (idx < MASK_BYTES)
          data_o = {24'd0, mask_sel[8*idx +: 8]};
      end
      PK_RANGE: begin
        len_o = 32'(RANGE_WORDS);
        if (idx < RANGE_WORDS) begin
          case (idx_i[1:0])
            2'd0:    data_o = ABS_MIN[32*(idx/4) +: 32];
            2'd1:    data_o = ABS_MAX[32*(idx/4) +: 32];
            default: data_o = '0;
          endcase
        end
      end
      default: begin
        len_o  = '0;
        data_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/evq_irq_gate.sv
module evq_irq_gate #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [CW-1:0] level_i,
  output logic          armed_o,
  output logic          irq_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (arm_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed_o = armed_q;
  assign irq_o   = armed_q && (int'(level_i) >= 3);

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R7
endmodule

// File: rtl/evq_input_dev.sv
module evq_input_dev
  import evq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH_WORDS = 24,
  parameter int NAME_CHARS = 6,
  parameter logic [8*NAME_CHARS-1:0] NAME_TEXT = "evqkbd",
  parameter int MASK_BYTES = 4,
  parameter logic [8*MASK_BYTES-1:0] KEY_MASK = 32'h0000_1F06,
  parameter logic [8*MASK_BYTES-1:0] REL_MASK = 32'h0000_0003,
  parameter logic [8*MASK_BYTES-1:0] ABS_MASK = 32'h0000_0007,
  parameter int ABS_AXES = 3,
  parameter logic [32*ABS_AXES-1:0] ABS_MIN = {32'd0, 32'd16, 32'd0},
  parameter logic [32*ABS_AXES-1:0] ABS_MAX = {32'd1, 32'd479, 32'd319}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [31:0]       ev_type,
  input  logic [31:0]       ev_code,
  input  logic [31:0]       ev_value,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CW    = $clog2(DEPTH_WORDS + 1);

  logic             rst_ni;
  logic             at_pop, at_len, at_data;
  logic             pop, arm, page_we;
  logic [IDX_W-1:0] data_idx;
  word_t            page_q, page_d;
  word_t            head, pg_len, pg_data;
  logic [CW-1:0]    level;
  logic             armed;

  evq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  // address decode
  always_comb begin
    at_pop   = int'(bus_addr) == OFS_POP;
    at_len   = int'(bus_addr) == OFS_LEN;
    at_data  = (int'(bus_addr) >= OFS_DATA) && (bus_addr[1:0] == 2'b00);
    data_idx = bus_addr[ADDR_W-1:2] - IDX_W'(OFS_DATA / 4);
    pop      = bus_rd && at_pop;
    page_we  = bus_wr && at_pop;
    arm      = bus_rd && at_len && (page_q == PG_RANGE);
  end

  always_comb begin
    page_d = page_q;
    if (page_we) page_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) page_q <= PG_NAME;
    else         page_q <= page_d;
  end

  evq_word_ring #(.DEPTH(DEPTH_WORDS)) u_ring (
    .clk     (clk),
    .rst_n   (rst_ni),
    .push_i  (ev_valid),
    .w0_i    (ev_type),
    .w1_i    (ev_code),
    .w2_i    (ev_value),
    .pop_i   (pop),
    .head_o  (head),
    .level_o (level)
  );

  evq_page_rom #(
    .IDX_W      (IDX_W),
    .NAME_CHARS (NAME_CHARS),
    .NAME_TEXT  (NAME_TEXT),
    .MASK_BYTES (MASK_BYTES),
    .KEY_MASK   (KEY_MASK),
    .REL_MASK   (REL_MASK),
    .ABS_MASK   (ABS_MASK),
    .ABS_AXES   (ABS_AXES),
    .ABS_MIN    (ABS_MIN),
    .ABS_MAX    (ABS_MAX)
  ) u_pages (
    .page_i (page_q),
    .idx_i  (data_idx),
    .len_o  (pg_len),
    .data_o (pg_data)
  );

  evq_irq_gate #(.CW(CW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_ni),
    .arm_i   (arm),
    .level_i (level),
    .armed_o (armed),
    .irq_o   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (at_pop)       bus_rdata = head;
    else if (at_len)  bus_rdata = pg_len;
    else if (at_data) bus_rdata = pg_data;
  end

  AST_QUIET_BEFORE_ARM: assert property (@(posedge clk) disable iff (!rst_ni)
    !armed |-> !irq); // R5
  AST_IRQ_LOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    (level == '0) |-> !irq); // R6
  AST_SIDE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && !at_pop && !ev_valid) |=> $stable(level)); // R11
endmodule

// File: tb/evq_input_dev_bench.sv
module evq_input_dev_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 24;
  localparam logic [31:0] PG_RANGE = 32'h0002_0003;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid;
  logic [31:0] ev_type, ev_code, ev_value;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_q[$];
  logic        model_armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_input_dev u_evq_input_dev (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_code(ev_code), .ev_value(ev_value), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return model_armed && (model_q.size() >= 3);
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] t, input logic [31:0] c, input logic [31:0] v);
    @(negedge clk);
    ev_valid = 1'b1; ev_type = t; ev_code = c; ev_value = v;
    if (DEPTH - model_q.size() >= 3) begin
      model_q.push_back(t); model_q.push_back(c); model_q.push_back(v);
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [31:0] d, e;
    e = (model_q.size() != 0) ? model_q.pop_front() : 32'h0;
    rd(8'h00, d);
    check(req, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  name [6];
    name[0] = 8'h65; name[1] = 8'h76; name[2] = 8'h71;
    name[3] = 8'h6b; name[4] = 8'h62; name[5] = 8'h64;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ev_valid = 1'b0; ev_type = '0; ev_code = '0; ev_value = '0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h04, d); check("R1 name page len", d, 32'd6);
    pop_check("R1 empty read");

    // R5: events stored before arming, irq quiet
    push(32'd1, 32'd30, 32'd1);
    push(32'd3, 32'd0, 32'd250);
    check("R5 quiet before arm", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h0001_0001);
    rd(8'h04, d); check("R8 key mask len", d, 32'd4);
    check("R7 other page len no arm", {31'd0, irq}, 32'd0);
    wr(8'h00, PG_RANGE);
    rd(8'h04, d); check("R8 range len", d, 32'd12);
    model_armed = 1'b1;
    check("R5 armed irq", {31'd0, irq}, {31'd0, exp_irq()});

    // R10: range table
    for (int k = 0; k < 3; k++) begin
      logic [31:0] mn, mx;
      mn = (k == 1) ? 32'd16 : 32'd0;
      mx = (k == 0) ? 32'd319 : (k == 1) ? 32'd479 : 32'd1;
      rd(8'(8 + 16*k), d);  check("R10 min", d, mn);
      rd(8'(12 + 16*k), d); check("R10 max", d, mx);
      rd(8'(16 + 16*k), d); check("R10 fuzz", d, 32'd0);
      rd(8'(20 + 16*k), d); check("R10 flat", d, 32'd0);
    end
    rd(8'(8 + 4*12), d); check("R9 range past end", d, 32'd0);

    // R9: name and masks
    wr(8'h00, 32'h0);
    for (int i = 0; i < 6; i++) begin
      rd(8'(8 + 4*i), d); check("R9 name char", d, {24'd0, name[i]});
    end
    rd(8'(8 + 4*6), d); check("R9 name past end", d, 32'd0);
    wr(8'h00, 32'h0001_0001);
    rd(8'h08, d); check("R9 key byte0", d, 32'h06);
    rd(8'h0C, d); check("R9 key byte1", d, 32'h1F);
    rd(8'h18, d); check("R9 key past end", d, 32'h0);
    wr(8'h00, 32'h0001_0002);
    rd(8'h08, d); check("R9 rel byte0", d, 32'h03);
    wr(8'h00, 32'h0001_0000);
    rd(8'h04, d); check("R8 syn page len", d, 32'd0);
    wr(8'h00, 32'h0001_2345);
    rd(8'h04, d); check("R8 unknown page len", d, 32'd0);
    rd(8'h08, d); check("R8 unknown page data", d, 32'd0);

    // R11: ignored write, store untouched by side reads
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h1234_5678);
    rd(8'h04, d); check("R11 page kept", d, 32'd0);
    check("R7 still armed", {31'd0, irq}, 32'd1);

    // R2 / R6: drain two events word by word
    for (int i = 0; i < 6; i++) begin
      pop_check("R2 word order");
      check("R6 irq track", {31'd0, irq}, {31'd0, exp_irq()});
    end
    pop_check("R4 empty read");
    push(32'd2, 32'd1, 32'hFFFF_FFFE);
    pop_check("R4 no pointer move");
    pop_check("R4 second word");
    pop_check("R4 third word");

    // R3: overfill
    for (int i = 0; i < 9; i++) push(32'd1, 32'(100 + i), 32'(i));
    check("R3 full irq", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 25; i++) pop_check("R3 drop whole event");
    push(32'd1, 32'd5, 32'd5);
    push(32'd1, 32'd6, 32'd6);
    pop_check("R6 partial");
    pop_check("R6 partial");
    pop_check("R6 partial");
    pop_check("R6 partial");
    check("R6 two words left irq low", {31'd0, irq}, 32'd0);
    pop_check("R6 partial");
    pop_check("R6 partial");

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 99) < 45)
        push($urandom(), $urandom(), $urandom());
      else
        pop_check("R2 random pop");
      check("R6 random irq", {31'd0, irq}, {31'd0, exp_irq()});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule